// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches the clock and data lines of a two-wire open-drain serial bus (I2C style) and reports what happens on them. It never drives the bus. Both lines first pass through multi-flop synchronizers. The monitor then finds the bus conditions: a data-line edge while the clock is high. A falling data edge opens or continues a transaction, and a rising data edge closes it. The monitor keeps a bus-busy level, and it tells a first START apart from a repeated START by whether a STOP came between them.

The monitor assembles every 9-bit frame, eight data bits (most significant first) and one acknowledge bit, and reports the result as a byte and a not-acknowledged flag. It decodes the first byte of each message as an address. The address may be a plain 7-bit address with a direction bit, a general call or a START byte. It may also be a 10-bit address, whose two-byte header is decoded into one 10-bit value. A 10-bit read header sent after a repeated START reuses the low address byte of the last 10-bit write header. Other blocks use these outputs to trace the bus, to trigger on traffic, or to build a target on top of the monitor.

Top module: `tw_bus_observer`

## Requirements
- R1: After reset `busy_o` is 0. A falling data edge while the clock stays high, seen while the bus is idle, pulses `start_pulse_o` for one cycle and sets `busy_o`.
- R2: A falling data edge while the clock stays high, seen while `busy_o` is 1, pulses `restart_pulse_o` and not `start_pulse_o`. `busy_o` stays 1.
- R3: A rising data edge while the clock stays high pulses `stop_pulse_o` and clears `busy_o`, but only while the bus is busy. The same edge on an idle bus produces no pulse.
- R4: While the bus is busy, data is sampled on each rising clock edge, most significant bit first. The 9th sample ends the frame. It pulses `frame_done_o` and presents the first eight bits on `frame_byte_o` and the 9th bit on `frame_nack_o` (0 = acknowledged, 1 = not acknowledged).
- R5: Any START or repeated START discards a partly received frame, and bit counting restarts from zero.
- R6: A data edge that lands in the same synchronized sample as a rising clock edge is taken as a data bit, never as a bus condition.
- R7: The first frame of each message pulses `addr_valid_o` one cycle after its `frame_done_o`, unless it is a 10-bit write header. It reports `addr_o` = {3'b000, byte[7:1]} and `addr_read_o` = byte[0] (1 = read), with `addr_ten_o` = 0. Later frames of the message produce no address pulse.
- R8: A first byte of 0x00 sets `gen_call_o`, and a first byte of 0x01 sets `start_byte_o`, alongside the `addr_valid_o` pulse. At most one of `gen_call_o`, `start_byte_o` and `addr_ten_o` is set.
- R9: A first byte 11110xx0 (bits 7..3 = 11110, bit 0 = 0) gives no address pulse of its own. The following frame completes the address: `addr_o` = {xx, second byte}, `addr_ten_o` = 1, `addr_read_o` = 0.
- R10: A first byte 11110xx1 pulses `addr_valid_o` right away, with `addr_ten_o` = 1 and `addr_read_o` = 1. It reports `addr_o` = {xx, low byte of the most recent 10-bit write address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Raw bus clock line level |
| bus_dat_i | input | 1 | Raw bus data line level |
| start_pulse_o | output | 1 | First START seen |
| restart_pulse_o | output | 1 | Repeated START seen |
| stop_pulse_o | output | 1 | STOP seen |
| busy_o | output | 1 | Transaction in progress |
| frame_done_o | output | 1 | 9-bit frame completed |
| frame_byte_o | output | 8 | Data byte of the last frame |
| frame_nack_o | output | 1 | Acknowledge bit of the last frame (1 = NACK) |
| addr_valid_o | output | 1 | Address decoded |
| addr_o | output | 10 | Decoded address |
| addr_read_o | output | 1 | Direction of the decoded address (1 = read) |
| addr_ten_o | output | 1 | Address came from a 10-bit header |
| gen_call_o | output | 1 | General call |
| start_byte_o | output | 1 | START byte |

## Verification
A bit capture and a condition check can meet in the same sample when the data line changes in the very sample in which the clock rises. The bench provokes this with a whole address byte sent with every data change made in the same cycle as the rising clock. This produces both a data fall and a data rise under a rising clock. The result counts as correct only if the byte arrives intact and no START, repeated START or STOP pulse appears in that byte.

// File: rtl/tw_obs_pkg.sv
package tw_obs_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 10;
   localparam logic [4:0] TEN_HDR_TAG = 5'b11110;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              rd;
      logic              ten;
      logic              gcall;
      logic              sbyte;
   } addr_info_t;

   function automatic logic is_ten_hdr(input logic [BYTE_W-1:0] b);
      return b[BYTE_W-1 -: 5] == TEN_HDR_TAG;
   endfunction

endpackage

// File: rtl/tw_obs_sync.sv
module tw_obs_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_depth
      $error("tw_obs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= RST_VAL;
            else         chain_q[i] <= d_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= RST_VAL;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_obs_cond.sv
module tw_obs_cond (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic start_o,
   output logic rstart_o,
   output logic stop_o,
   output logic busy_o,
   output logic clk_rise_o,
   output logic cond_start_o,
   output logic cond_stop_o
);

   logic prev_c_q, prev_d_q;
   logic clk_hold, dat_fall, dat_rise;
   logic start_q, rstart_q, stop_q, busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_c_q <= 1'b1;
         prev_d_q <= 1'b1;
      end else begin
         prev_c_q <= scl_s_i;
         prev_d_q <= sda_s_i;
      end
   end

   always_comb begin
      clk_hold     = scl_s_i & prev_c_q;
      dat_fall     = prev_d_q & ~sda_s_i;
      dat_rise     = ~prev_d_q & sda_s_i;
      cond_start_o = clk_hold & dat_fall;
      cond_stop_o  = clk_hold & dat_rise;
      clk_rise_o   = scl_s_i & ~prev_c_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q  <= 1'b0;
         rstart_q <= 1'b0;
         stop_q   <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         start_q  <= cond_start_o & ~busy_q;
         rstart_q <= cond_start_o & busy_q;
         stop_q   <= cond_stop_o & busy_q;
         if (cond_start_o)     busy_q <= 1'b1;
         else if (cond_stop_o) busy_q <= 1'b0;
      end
   end

   assign start_o  = start_q;
   assign rstart_o = rstart_q;
   assign stop_o   = stop_q;
   assign busy_o   = busy_q;

   p_start_from_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |-> busy_q && !$past(busy_q));
   p_rstart_when_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rstart_q |-> busy_q && $past(busy_q));
   p_stop_frees_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_q |-> !busy_q && $past(busy_q));
   p_events_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({start_q, rstart_q, stop_q}));

endmodule

// File: rtl/tw_obs_frame.sv
module tw_obs_frame
   import tw_obs_pkg::*;
#(
   parameter int W = BYTE_W,
   localparam int CW = $clog2(W + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         busy_i,
   input  logic         clk_rise_i,
   input  logic         cond_start_i,
   input  logic         cond_stop_i,
   input  logic         dat_i,
   output logic         done_o,
   output logic [W-1:0] byte_o,
   output logic         nack_o,
   output logic         first_o,
   output logic         second_o
);

   if (W < 2) begin : g_bad_width
      $error("tw_obs_frame: W must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sh_q, byte_q;
   logic [1:0]    idx_q;
   logic          done_q, nack_q, first_q, second_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         sh_q     <= '0;
         byte_q   <= '0;
         idx_q    <= '0;
         done_q   <= 1'b0;
         nack_q   <= 1'b0;
         first_q  <= 1'b0;
         second_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (cond_start_i || cond_stop_i) begin
            cnt_q <= '0;
            idx_q <= '0;
         end else if (busy_i && clk_rise_i) begin
            if (cnt_q == CW'(W)) begin
               done_q   <= 1'b1;
               byte_q   <= sh_q;
               nack_q   <= dat_i;
               first_q  <= (idx_q == 2'd0);
               second_q <= (idx_q == 2'd1);
               cnt_q    <= '0;
               if (idx_q != 2'd2) idx_q <= idx_q + 2'd1;
            end else begin
               sh_q  <= {sh_q[W-2:0], dat_i};
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign done_o   = done_q;
   assign byte_o   = byte_q;
   assign nack_o   = nack_q;
   assign first_o  = first_q;
   assign second_o = second_q;

   p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(W));
   p_done_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> $past(clk_rise_i) && $past(busy_i));
   p_restart_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_start_i |=> cnt_q == '0 && !done_q);

endmodule

// File: rtl/tw_obs_addr.sv
module tw_obs_addr
   import tw_obs_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              done_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              first_i,
   input  logic              second_i,
   input  logic              msg_start_i,
   output logic              valid_o,
   output addr_info_t        info_o
);

   logic              hdr_hit;
   logic              pend_q, valid_q;
   logic [1:0]        hi_q;
   logic [BYTE_W-1:0] low_q;
   addr_info_t        info_q;

   if (TEN_BIT_EN) begin : g_ten_decode
      assign hdr_hit = is_ten_hdr(byte_i);
   end else begin : g_seven_only
      assign hdr_hit = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         hi_q    <= '0;
         low_q   <= '0;
         info_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (msg_start_i) pend_q <= 1'b0;
         if (done_i && first_i) begin
            if (hdr_hit && !byte_i[0]) begin
               pend_q <= 1'b1;
               hi_q   <= byte_i[2:1];
            end else if (hdr_hit) begin
               valid_q <= 1'b1;
               info_q  <= '{addr: {byte_i[2:1], low_q}, rd: 1'b1, ten: 1'b1,
                            gcall: 1'b0, sbyte: 1'b0};
            end else begin
               valid_q <= 1'b1;
               info_q  <= '{addr: {3'b000, byte_i[BYTE_W-1:1]}, rd: byte_i[0],
                            ten: 1'b0, gcall: (byte_i == 8'h00),
                            sbyte: (byte_i == 8'h01)};
            end
         end else if (done_i && second_i && pend_q) begin
            valid_q <= 1'b1;
            pend_q  <= 1'b0;
            low_q   <= byte_i;
            info_q  <= '{addr: {hi_q, byte_i}, rd: 1'b0, ten: 1'b1,
                         gcall: 1'b0, sbyte: 1'b0};
         end
      end
   end

   assign valid_o = valid_q;
   assign info_o  = info_q;

   p_addr_after_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> $past(done_i));
   p_class_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> $onehot0({info_q.gcall, info_q.sbyte, info_q.ten}));
   p_ten_write_waits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && first_i && hdr_hit && !byte_i[0]) |=> !valid_q);

endmodule

// File: rtl/tw_bus_observer.sv
module tw_bus_observer
   import tw_obs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit TEN_BIT_EN  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_clk_i,
   input  logic              bus_dat_i,
   output logic              start_pulse_o,
   output logic              restart_pulse_o,
   output logic              stop_pulse_o,
   output logic              busy_o,
   output logic              frame_done_o,
   output logic [BYTE_W-1:0] frame_byte_o,
   output logic              frame_nack_o,
   output logic              addr_valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_read_o,
   output logic              addr_ten_o,
   output logic              gen_call_o,
   output logic              start_byte_o
);

   logic       scl_s, sda_s;
   logic       clk_rise, cond_start, cond_stop;
   logic       first_f, second_f;
   addr_info_t info;

   tw_obs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_clk_i), .q_o(scl_s));

   tw_obs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_dat_i), .q_o(sda_s));

   tw_obs_cond u_cond (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .scl_s_i     (scl_s),
      .sda_s_i     (sda_s),
      .start_o     (start_pulse_o),
      .rstart_o    (restart_pulse_o),
      .stop_o      (stop_pulse_o),
      .busy_o      (busy_o),
      .clk_rise_o  (clk_rise),
      .cond_start_o(cond_start),
      .cond_stop_o (cond_stop)
   );

   tw_obs_frame #(.W(BYTE_W)) u_frame (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .busy_i      (busy_o),
      .clk_rise_i  (clk_rise),
      .cond_start_i(cond_start),
      .cond_stop_i (cond_stop),
      .dat_i       (sda_s),
      .done_o      (frame_done_o),
      .byte_o      (frame_byte_o),
      .nack_o      (frame_nack_o),
      .first_o     (first_f),
      .second_o    (second_f)
   );

   tw_obs_addr #(.TEN_BIT_EN(TEN_BIT_EN)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (frame_done_o),
      .byte_i     (frame_byte_o),
      .first_i    (first_f),
      .second_i   (second_f),
      .msg_start_i(cond_start),
      .valid_o    (addr_valid_o),
      .info_o     (info)
   );

   assign addr_o       = info.addr;
   assign addr_read_o  = info.rd;
   assign addr_ten_o   = info.ten;
   assign gen_call_o   = info.gcall;
   assign start_byte_o = info.sbyte;

   p_frame_not_cond_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done_o |-> !start_pulse_o && !restart_pulse_o && !stop_pulse_o);

endmodule

// File: tb/tw_bus_observer_bench.sv
module tw_bus_observer_bench;

   localparam int HOLD = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda = 1'b1;

   logic       st_p, rs_p, sp_p, busy, fdone, fnack, avld, ard, aten, agc, asb;
   logic [7:0] fbyte;
   logic [9:0] aval;

   always #2 clk = ~clk;

   tw_bus_observer u_tw_bus_observer (
      .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(scl), .bus_dat_i(sda),
      .start_pulse_o(st_p), .restart_pulse_o(rs_p), .stop_pulse_o(sp_p),
      .busy_o(busy), .frame_done_o(fdone), .frame_byte_o(fbyte),
      .frame_nack_o(fnack), .addr_valid_o(avld), .addr_o(aval),
      .addr_read_o(ard), .addr_ten_o(aten), .gen_call_o(agc),
      .start_byte_o(asb));

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   // observed log
   int n_st, n_rs, n_sp, nb, na;
   logic [7:0] got_b [32];
   logic       got_n [32];
   logic [9:0] got_a [32];
   logic [3:0] got_f [32];   // {rd, ten, gcall, sbyte}
   // expected log
   int e_nb, e_na;
   logic [7:0] exp_b [32];
   logic       exp_n [32];
   logic [9:0] exp_a [32];
   logic [3:0] exp_f [32];

   always @(negedge clk) begin
      if (st_p) n_st++;
      if (rs_p) n_rs++;
      if (sp_p) n_sp++;
      if (fdone && nb < 32) begin got_b[nb] = fbyte; got_n[nb] = fnack; nb++; end
      if (avld && na < 32) begin
         got_a[na] = aval; got_f[na] = {ard, aten, agc, asb}; na++;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic clear_log();
      n_st = 0; n_rs = 0; n_sp = 0; nb = 0; na = 0; e_nb = 0; e_na = 0;
   endtask

   task automatic step();
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b0; step(); scl = 1'b0; step();
   endtask

   task automatic bus_rstart();
      sda = 1'b1; step(); scl = 1'b1; step(); sda = 1'b0; step(); scl = 1'b0; step();
   endtask

   task automatic bus_stop();
      sda = 1'b0; step(); scl = 1'b1; step(); sda = 1'b1; step(); step();
   endtask

   task automatic send_bit(input logic b);
      sda = b; step(); scl = 1'b1; step(); scl = 1'b0; step();
   endtask

   task automatic send_bit_same(input logic b);
      sda = b; scl = 1'b1; step(); scl = 1'b0; step();
   endtask

   task automatic send_byte(input logic [7:0] b, input logic ack_lvl);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      send_bit(ack_lvl);
   endtask

   function automatic logic [3:0] exp_flags7(input logic [7:0] b);
      return {b[0], 1'b0, b == 8'h00, b == 8'h01};
   endfunction

   task automatic push_byte(input logic [7:0] b, input logic n);
      exp_b[e_nb] = b; exp_n[e_nb] = n; e_nb++;
   endtask

   task automatic push_addr(input logic [9:0] a, input logic [3:0] f);
      exp_a[e_na] = a; exp_f[e_na] = f; e_na++;
   endtask

   task automatic push_addr7(input logic [7:0] b);
      push_addr({3'b000, b[7:1]}, exp_flags7(b));
   endtask

   task automatic compare(input string tag, input int e_st, input int e_rs, input int e_sp);
      chk(n_st == e_st, tag, "start pulses (R1)", n_st, e_st);
      chk(n_rs == e_rs, tag, "restart pulses (R2)", n_rs, e_rs);
      chk(n_sp == e_sp, tag, "stop pulses (R3)", n_sp, e_sp);
      chk(busy == 1'b0, tag, "busy after stop (R3)", busy, 0);
      chk(nb == e_nb, tag, "frame count (R4)", nb, e_nb);
      for (int i = 0; i < e_nb && i < nb; i++) begin
         chk(got_b[i] == exp_b[i], tag, "frame byte (R4)", got_b[i], exp_b[i]);
         chk(got_n[i] == exp_n[i], tag, "frame ack bit (R4)", got_n[i], exp_n[i]);
      end
      chk(na == e_na, tag, "address count (R7)", na, e_na);
      for (int i = 0; i < e_na && i < na; i++) begin
         chk(got_a[i] == exp_a[i], tag, "address value (R7)", got_a[i], exp_a[i]);
         chk(got_f[i] == exp_f[i], tag, "address flags rd/ten/gc/sb (R8)", got_f[i], exp_f[i]);
      end
   endtask

   function automatic logic [7:0] rand_addr_byte(input logic rw);
      logic [6:0] a7 = 7'($urandom_range(0, 127));
      if (a7[6:2] == 5'b11110) a7[6] = 1'b0;
      return {a7, rw};
   endfunction

   initial begin
      logic [7:0] b, d;
      logic       k;
      void'($urandom(32'h5eed_0042));
      clear_log();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      step();

      // R1: reset state
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(n_st + n_rs + n_sp + nb + na == 0, "R1", "no events after reset", n_st + n_rs + n_sp + nb + na, 0);

      // R3: stop-shaped edge on an idle bus
      clear_log();
      scl = 1'b0; step(); sda = 1'b0; step(); scl = 1'b1; step(); sda = 1'b1; step(); step();
      compare("R3 idle stop", 0, 0, 0);

      // R1/R4/R7: plain write with data
      clear_log();
      bus_start();
      step();
      chk(busy == 1'b1, "R1", "busy after start", busy, 1);
      send_byte(8'hA0, 1'b0); push_byte(8'hA0, 1'b0); push_addr7(8'hA0);
      send_byte(8'h3C, 1'b1); push_byte(8'h3C, 1'b1);
      bus_stop();
      compare("R7 write", 1, 0, 1);

      // R8: general call, then START byte
      clear_log();
      bus_start(); send_byte(8'h00, 1'b0); push_byte(8'h00, 1'b0); push_addr7(8'h00);
      send_byte(8'h06, 1'b0); push_byte(8'h06, 1'b0);
      bus_stop();
      compare("R8 general call", 1, 0, 1);
      clear_log();
      bus_start(); send_byte(8'h01, 1'b1); push_byte(8'h01, 1'b1); push_addr7(8'h01);
      bus_stop();
      compare("R8 start byte", 1, 0, 1);

      // R9/R10/R2: 10-bit write header, repeated start, 10-bit read header
      clear_log();
      bus_start();
      send_byte(8'hF6, 1'b0); push_byte(8'hF6, 1'b0);
      send_byte(8'h5A, 1'b0); push_byte(8'h5A, 1'b0);
      push_addr(10'h35A, 4'b0100);
      send_byte(8'h11, 1'b0); push_byte(8'h11, 1'b0);
      bus_rstart();
      chk(busy == 1'b1, "R2", "busy kept over repeated start", busy, 1);
      send_byte(8'hF7, 1'b0); push_byte(8'hF7, 1'b0);
      push_addr(10'h35A, 4'b1100);
      send_byte(8'h99, 1'b1); push_byte(8'h99, 1'b1);
      bus_stop();
      compare("R9 R10 ten-bit", 1, 1, 1);

      // R5: partial frame cut by a repeated start
      clear_log();
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      bus_rstart();
      send_byte(8'h42, 1'b0); push_byte(8'h42, 1'b0); push_addr7(8'h42);
      bus_stop();
      compare("R5 partial frame", 1, 1, 1);

      // R6: data changes in the same sample as the rising clock
      clear_log();
      bus_start();
      b = 8'hA5;
      for (int i = 7; i >= 0; i--) send_bit_same(b[i]);
      send_bit_same(1'b0);
      push_byte(8'hA5, 1'b0); push_addr7(8'hA5);
      bus_stop();
      compare("R6 same-sample edges", 1, 0, 1);

      // random traffic
      for (int t = 0; t < 20; t++) begin
         clear_log();
         bus_start();
         b = rand_addr_byte(1'($urandom_range(0, 1)));
         send_byte(b, 1'b0); push_byte(b, 1'b0); push_addr7(b);
         for (int j = 0; j < int'($urandom_range(0, 3)); j++) begin
            d = 8'($urandom_range(0, 255)); k = 1'($urandom_range(0, 1));
            send_byte(d, k); push_byte(d, k);
         end
         k = 1'($urandom_range(0, 1));
         if (k) begin
            bus_rstart();
            b = rand_addr_byte(1'b1);
            send_byte(b, 1'b0); push_byte(b, 1'b0); push_addr7(b);
            d = 8'($urandom_range(0, 255));
            send_byte(d, 1'b1); push_byte(d, 1'b1);
         end
         bus_stop();
         compare("R7 random", 1, k ? 1 : 0, 1);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule